// File: doc/BRIEF.md
# Serial Audio Transmit Sample Path

This block sits between the transmit holding register of a multi-channel serial audio port and its bit serializer. Software or a DMA engine writes 32-bit words into the holding register. Each time the serializer opens a channel slot, it raises a request with the channel index. The block then returns the sample for that slot, right-justified and zero-extended to 32 bits. In the two packed stereo modes, one written word feeds two consecutive slots. The lower half is used first (left) and the upper half second (right).

When a slot comes up and no word is waiting, the block raises a sticky underrun flag and marks the channel that starved in a per-channel vector. The sample it returns is selected by the repeat mode bit. With the bit clear it sends zero. With the bit set it sends the last sample already sent on that same channel, which it keeps in a small per-channel store. Both kinds of flag stay set until a write-one-to-clear pulse removes them. Mode inputs are expected to change only while the holding register is empty.

Top module: `audio_tx_path`

## Requirements
- R1: After reset, `tx_ready` is 1, `underrun` is 0, `und_chan` is all zeros and `smp_valid` is 0.
- R2: A write (`wr_valid`) seen while `tx_ready` is 1 loads the holding register, and `tx_ready` is 0 after that clock edge. A write seen while `tx_ready` is 0 is ignored, so the word already held is the one sent.
- R3: A request (`slot_req`) sampled at one clock edge produces `smp_valid` = 1 and the sample on `smp_data` after the second following edge. Without compact mode, width code 0 (8 bits) sends word bits 7:0, code 1 (16 bits) sends bits 15:0 and code 2 (32 bits) sends the whole word, each zero-extended.
- R4: With compact mode on and width code 1, the first request after a write sends bits 15:0 and the second sends bits 31:16. `tx_ready` stays 0 between them.
- R5: With compact mode on and width code 0, the first request after a write sends bits 7:0 and the second sends bits 15:8.
- R6: A request made while the holding register is empty (`tx_ready` = 1) sets `underrun` and bit `slot_ch` of `und_chan` at that edge. The other bits are not changed.
- R7: With `mode_repeat` = 0, an underrun slot sends the value zero.
- R8: With `mode_repeat` = 1, an underrun slot sends the last sample sent on the same channel. It sends zero if that channel has sent nothing since reset.
- R9: `underrun` stays set until `clr_global` is pulsed. Each `und_chan` bit stays set until the matching `clr_chan` bit is pulsed. A new underrun in the same cycle takes priority over a clear.
- R10: The request that consumes the last part of a held word returns `tx_ready` to 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Holding register write strobe |
| wr_data | input | 32 | Holding register write data |
| slot_req | input | 1 | Serializer asks for the next sample |
| slot_ch | input | CH_W | Channel index of the requested slot |
| mode_width | input | 2 | Sample width: 0 = 8, 1 = 16, 2 = 32 bits |
| mode_compact | input | 1 | Packed stereo, two samples per word |
| mode_repeat | input | 1 | On underrun repeat the previous channel sample |
| clr_global | input | 1 | Write-one-to-clear for `underrun` |
| clr_chan | input | NUM_CH | Write-one-to-clear mask for `und_chan` |
| smp_valid | output | 1 | Sample on `smp_data` is new |
| smp_data | output | 32 | Right-justified sample for the slot |
| tx_ready | output | 1 | Holding register is empty |
| underrun | output | 1 | Sticky underrun flag |
| und_chan | output | NUM_CH | Sticky per-channel underrun bits |

## Verification
The bench builds the block with NUM_CH = 4, not the default of two. Channel indices 2 and 3 can then be reached, which shows that an underrun marks only its own bit and that a channel which has never sent anything repeats zero. Four channels also let each channel's stored sample be checked against its neighbours, because different channels are given different previous samples before the repeat underruns are forced.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SW_8  = 2'd0,
    SW_16 = 2'd1,
    SW_32 = 2'd2
  } smp_width_e;

  // Right-justified extraction of one sample from the held word.
  function automatic logic [WORD_W-1:0] pick_sample(
    input logic [WORD_W-1:0] word,
    input logic [1:0]        width,
    input logic              packed_on,
    input logic              upper
  );
    logic [WORD_W-1:0] res;
    res = '0;
    if (packed_on && width == SW_8) begin
      res[7:0] = upper ? word[15:8] : word[7:0];
    end else if (packed_on && width == SW_16) begin
      res[15:0] = upper ? word[31:16] : word[15:0];
    end else if (width == SW_8) begin
      res[7:0] = word[7:0];
    end else if (width == SW_16) begin
      res[15:0] = word[15:0];
    end else begin
      res = word;
    end
    return res;
  endfunction
endpackage

// File: rtl/audio_tx_hold.sv
module audio_tx_hold
  import audio_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  input  logic              split,
  output logic              full,
  output logic              upper,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      upper <= 1'b0;
      word  <= '0;
    end else if (!full) begin
      if (wr_valid) begin
        full  <= 1'b1;
        upper <= 1'b0;
        word  <= wr_data;
      end
    end else if (take) begin
      if (split && !upper) begin
        upper <= 1'b1;
      end else begin
        full  <= 1'b0;
        upper <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_tx_prevmem.sv
module audio_tx_prevmem #(
  parameter  int NUM_CH = 2,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   wch,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [CH_W-1:0]   rch,
  output logic [DATA_W-1:0] rdata,
  output logic              rseen
);
  logic [DATA_W-1:0] mem [NUM_CH];
  logic [NUM_CH-1:0] seen;

  // Plain synchronous write and read, suitable for RAM inference.
  always_ff @(posedge clk) begin
    if (we) mem[wch] <= wdata;
    if (re) rdata <= mem[rch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= '0;
      rseen <= 1'b0;
    end else begin
      if (we) seen[wch] <= 1'b1;
      if (re) rseen <= seen[rch];
    end
  end
endmodule

// File: rtl/audio_tx_flags.sv
module audio_tx_flags #(
  parameter  int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [CH_W-1:0]   hit_ch,
  input  logic              clr_global,
  input  logic [NUM_CH-1:0] clr_chan,
  output logic              underrun,
  output logic [NUM_CH-1:0] und_chan
);
  logic [NUM_CH-1:0] hit_vec;

  always_comb begin
    hit_vec = '0;
    if (hit) hit_vec[hit_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      underrun <= 1'b0;
      und_chan <= '0;
    end else begin
      underrun <= hit | (underrun & ~clr_global);
      und_chan <= hit_vec | (und_chan & ~clr_chan);
    end
  end
endmodule

// File: rtl/audio_tx_path.sv
module audio_tx_path
  import audio_tx_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [31:0]       wr_data,
  input  logic              slot_req,
  input  logic [CH_W-1:0]   slot_ch,
  input  logic [1:0]        mode_width,
  input  logic              mode_compact,
  input  logic              mode_repeat,
  input  logic              clr_global,
  input  logic [NUM_CH-1:0] clr_chan,
  output logic              smp_valid,
  output logic [31:0]       smp_data,
  output logic              tx_ready,
  output logic              underrun,
  output logic [NUM_CH-1:0] und_chan
);
  logic              full, upper, split, starve;
  logic [WORD_W-1:0] word, cur_smp, prev_q;
  logic              prev_seen;
  logic              s1_valid, s1_und, s1_rep;
  logic [WORD_W-1:0] s1_smp;

  assign split    = mode_compact && (mode_width == SW_8 || mode_width == SW_16);
  assign tx_ready = !full;
  assign starve   = slot_req && !full;
  assign cur_smp  = pick_sample(word, mode_width, split, upper);

  audio_tx_hold u_hold (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(slot_req), .split(split), .full(full), .upper(upper), .word(word)
  );

  audio_tx_prevmem #(.NUM_CH(NUM_CH), .DATA_W(WORD_W)) u_prev (
    .clk(clk), .rst(rst), .we(slot_req && full), .wch(slot_ch), .wdata(cur_smp),
    .re(slot_req), .rch(slot_ch), .rdata(prev_q), .rseen(prev_seen)
  );

  audio_tx_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .hit(starve), .hit_ch(slot_ch),
    .clr_global(clr_global), .clr_chan(clr_chan),
    .underrun(underrun), .und_chan(und_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_und    <= 1'b0;
      s1_rep    <= 1'b0;
      s1_smp    <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      s1_valid  <= slot_req;
      s1_und    <= starve;
      s1_rep    <= mode_repeat;
      if (slot_req) s1_smp <= cur_smp;
      smp_valid <= s1_valid;
      if (s1_valid) begin
        if (!s1_und)                     smp_data <= s1_smp;
        else if (s1_rep && prev_seen)    smp_data <= prev_q;
        else                             smp_data <= '0;
      end
    end
  end
endmodule

// File: rtl/audio_tx_path_chk.sv
module audio_tx_path_chk #(
  parameter  int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [31:0]       wr_data,
  input logic              slot_req,
  input logic [CH_W-1:0]   slot_ch,
  input logic [1:0]        mode_width,
  input logic              mode_compact,
  input logic              mode_repeat,
  input logic              clr_global,
  input logic [NUM_CH-1:0] clr_chan,
  input logic              smp_valid,
  input logic [31:0]       smp_data,
  input logic              tx_ready,
  input logic              underrun,
  input logic [NUM_CH-1:0] und_chan
);
  // R2
  load_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && tx_ready && !slot_req) |=> !tx_ready);

  // R3
  sample_latency_chk: assert property (@(posedge clk) disable iff (rst)
    slot_req |-> ##2 smp_valid);

  // R6
  starve_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && tx_ready) |=> (underrun && und_chan[$past(slot_ch)]));

  // R7
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && tx_ready && !mode_repeat) |-> ##2 (smp_data == 32'd0));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && !clr_global) |=> underrun);

  // R9
  chan_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((und_chan & ~clr_chan) != '0) |=> ((und_chan & $past(und_chan & ~clr_chan)) == $past(und_chan & ~clr_chan)));
endmodule

bind audio_tx_path audio_tx_path_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_audio_tx_path.sv
module test_audio_tx_path;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_valid = 1'b0;
  logic [31:0]    wr_data = '0;
  logic           slot_req = 1'b0;
  logic [CW-1:0]  slot_ch = '0;
  logic [1:0]     mode_width = 2'd2;
  logic           mode_compact = 1'b0;
  logic           mode_repeat = 1'b0;
  logic           clr_global = 1'b0;
  logic [NCH-1:0] clr_chan = '0;
  logic           smp_valid;
  logic [31:0]    smp_data;
  logic           tx_ready;
  logic           underrun;
  logic [NCH-1:0] und_chan;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  audio_tx_path #(.NUM_CH(NCH)) i_audio_tx_path (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .slot_req(slot_req), .slot_ch(slot_ch), .mode_width(mode_width),
    .mode_compact(mode_compact), .mode_repeat(mode_repeat),
    .clr_global(clr_global), .clr_chan(clr_chan), .smp_valid(smp_valid),
    .smp_data(smp_data), .tx_ready(tx_ready), .underrun(underrun), .und_chan(und_chan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Request one slot; returns the sample seen two edges later.
  task automatic req(input int ch, output logic [31:0] s, output logic v);
    slot_req = 1'b1; slot_ch = CW'(ch);
    @(negedge clk);
    slot_req = 1'b0;
    @(negedge clk);
    s = smp_data; v = smp_valid;
  endtask

  task automatic clr(input logic g, input logic [NCH-1:0] m);
    clr_global = g; clr_chan = m;
    @(negedge clk);
    clr_global = 1'b0; clr_chan = '0;
  endtask

  task automatic t_reset;
    chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
    chk("R1 underrun", {31'd0, underrun}, 32'd0);
    chk("R1 und_chan", {28'd0, und_chan}, 32'd0);
    chk("R1 smp_valid", {31'd0, smp_valid}, 32'd0);
  endtask

  task automatic t_plain;
    logic [31:0] s; logic v;
    mode_compact = 1'b0;
    mode_width = 2'd2; wr(32'hDEADBEEF);
    chk("R2 ready low after load", {31'd0, tx_ready}, 32'd0);
    req(0, s, v);
    chk("R3 valid", {31'd0, v}, 32'd1);
    chk("R3 width32", s, 32'hDEADBEEF);
    chk("R10 ready back", {31'd0, tx_ready}, 32'd1);
    mode_width = 2'd0; wr(32'h12345678); req(1, s, v);
    chk("R3 width8", s, 32'h00000078);
    mode_width = 2'd1; wr(32'h12345678); req(2, s, v);
    chk("R3 width16", s, 32'h00005678);
    chk("R3 no underrun", {31'd0, underrun}, 32'd0);
  endtask

  task automatic t_ignored;
    logic [31:0] s; logic v;
    mode_width = 2'd2;
    wr(32'hAAAA0001); wr(32'hBBBB0002);
    req(3, s, v);
    chk("R2 write while full ignored", s, 32'hAAAA0001);
    chk("R2 ready after single word", {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_compact16;
    logic [31:0] s; logic v;
    mode_width = 2'd1; mode_compact = 1'b1;
    wr(32'hBBBBAAAA);
    req(0, s, v);
    chk("R4 left half", s, 32'h0000AAAA);
    chk("R4 ready held low", {31'd0, tx_ready}, 32'd0);
    req(1, s, v);
    chk("R4 right half", s, 32'h0000BBBB);
    chk("R10 ready after right", {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_compact8;
    logic [31:0] s; logic v;
    mode_width = 2'd0; mode_compact = 1'b1;
    wr(32'h9988CDAB);
    req(2, s, v);
    chk("R5 left byte", s, 32'h000000AB);
    req(3, s, v);
    chk("R5 right byte", s, 32'h000000CD);
    chk("R5 ready after pair", {31'd0, tx_ready}, 32'd1);
    mode_compact = 1'b0;
  endtask

  task automatic t_under_zero;
    logic [31:0] s; logic v;
    mode_repeat = 1'b0;
    req(2, s, v);
    chk("R7 zero fill", s, 32'd0);
    chk("R6 underrun set", {31'd0, underrun}, 32'd1);
    chk("R6 und_chan only ch2", {28'd0, und_chan}, 32'h4);
  endtask

  task automatic t_under_repeat;
    logic [31:0] s; logic v;
    mode_repeat = 1'b1;
    req(1, s, v);
    chk("R8 repeat ch1", s, 32'h0000BBBB);
    req(3, s, v);
    chk("R8 repeat ch3", s, 32'h000000CD);
    chk("R6 und_chan ch1 ch2 ch3", {28'd0, und_chan}, 32'hE);
    mode_repeat = 1'b0;
  endtask

  task automatic t_clear;
    clr(1'b0, 4'b0100);
    chk("R9 clear ch2 only", {28'd0, und_chan}, 32'hA);
    chk("R9 global stays", {31'd0, underrun}, 32'd1);
    clr(1'b1, 4'b0000);
    chk("R9 global cleared", {31'd0, underrun}, 32'd0);
    chk("R9 bits kept", {28'd0, und_chan}, 32'hA);
    // set beats clear in the same cycle
    clr_global = 1'b1; clr_chan = 4'b1111; slot_req = 1'b1; slot_ch = 2'd0;
    @(negedge clk);
    clr_global = 1'b0; clr_chan = '0; slot_req = 1'b0;
    chk("R9 set wins global", {31'd0, underrun}, 32'd1);
    chk("R9 set wins chan", {28'd0, und_chan}, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_never_sent;
    logic [31:0] s; logic v;
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    mode_repeat = 1'b1;
    req(1, s, v);
    chk("R8 repeat before any sample is zero", s, 32'd0);
    mode_repeat = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R10 actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_ignored();
    t_compact16();
    t_compact8();
    t_under_zero();
    t_under_repeat();
    t_clear();
    t_never_sent();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule